// File: doc/BRIEF.md
# Two-Pass Fractional Motion Vector Refiner

This block takes one block's integer motion vector and improves it to quarter-pel accuracy. Both vectors are held in quarter-pel units. A full fractional search would score 49 positions: the integer one, 8 half-pel positions and 40 quarter-pel positions. This block scores only 17 of them, in two passes. It first scores the integer centre. It then scores the eight half-pel neighbours of that centre, which lie at a distance of 2. Last, it scores the eight quarter-pel neighbours, at a distance of 1, of whichever point is best after those nine costs.

For each candidate the block asks an external interpolator for the prediction at that vector over a valid/ready request. The interpolator answers with the residue of the block, one row of four samples per cycle. The refiner turns each 4x4 group of rows into a Hadamard-domain SATD and adds a Lagrangian rate term for the vector difference. It keeps the cheapest candidate. After the seventeenth cost it reports the winning vector and its cost.

Top module: `frac_mv_refiner`

## Requirements
- R1: After reset, `busy`, `req_valid` and `done` are low and `best_cost` is zero.
- R2: A `start` pulse while idle launches a search. The first request carries the integer vector (`mv_int_x`, `mv_int_y`) sampled with `start`.
- R3: Requests 2 to 9 are the integer vector plus 2 times the neighbour offset k = 0..7. Requests 10 to 17 are the best vector after nine costs plus 1 times offset k = 0..7. The offset order (dx,dy) is (-1,-1), (0,-1), (1,-1), (-1,0), (1,0), (-1,1), (0,1), (1,1).
- R4: A request stays asserted with an unchanged vector until `req_ready` accepts it.
- R5: After each accepted request, 4*NBLK residue rows are taken on `res_valid`. Sample c of a row sits in bits [c*RW +: RW], as signed two's complement. Each four consecutive rows form one 4x4 sub-block. The candidate SATD is the sum over the sub-blocks of floor(sum of |H*R*H'| / 2), where H is the 4x4 Hadamard matrix with entries +-1.
- R6: The cost is SATD + lambda * (len(dx) + len(dy)), where d is the candidate minus the predictor (`mv_pred_*`). len(v) is the signed Exp-Golomb length 2*floor(log2(k+1))+1, with k = 2v-1 for v>0 and k = -2v otherwise.
- R7: A candidate replaces the incumbent only when its cost is strictly lower. On equal costs the earlier candidate stays.
- R8: After the 17th cost, `done` pulses for one cycle and `busy` drops. At the same time `best_mv_*` and `best_cost` show the winner and hold until the next start.
- R9: A `start` pulse during a search has no effect on the request sequence or on the result.
- R10: Residue rows presented while no request has been accepted are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a search when idle |
| mv_int_x | input | MVW | Integer-search vector, x, quarter-pel units |
| mv_int_y | input | MVW | Integer-search vector, y, quarter-pel units |
| mv_pred_x | input | MVW | Predictor vector for the rate term, x |
| mv_pred_y | input | MVW | Predictor vector for the rate term, y |
| lambda | input | LAMW | Lagrangian multiplier |
| req_valid | output | 1 | Candidate request pending |
| req_ready | input | 1 | Interpolator accepts the request |
| req_mv_x | output | MVW | Requested candidate vector, x |
| req_mv_y | output | MVW | Requested candidate vector, y |
| res_valid | input | 1 | Residue row valid |
| res_row | input | 4*RW | Four signed residue samples |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| best_mv_x | output | MVW | Refined vector, x |
| best_mv_y | output | MVW | Refined vector, y |
| best_cost | output | COSTW | Cost of the refined vector |

## Verification
The searches use several residue fields.
- In one, the residue energy is least at the integer centre, which shows whether the centre survives both passes.
- In one, the minimum sits off centre at a half-plus-quarter offset, which shows whether the second pass is centred on the pass-one winner.
- In one, the residue is all zero, so the costs are rate only and many tie. This separates strict from non-strict replacement and confirms the rate formula.
- In one, the samples are clipped at full scale and the vectors are negative. This exercises the datapath widths and sign handling.

Further searches add junk rows before a request is accepted, stray start pulses during a search, and a lambda large enough that the rate term dominates.

// File: rtl/frm_pkg.sv
package frm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT
    } frm_state_e;

    // neighbour ring order k = 0..7, row by row from top-left
    function automatic logic signed [1:0] nb_dx(input logic [2:0] k);
        case (k)
            3'd0, 3'd3, 3'd5: nb_dx = -2'sd1;
            3'd1, 3'd6:       nb_dx = 2'sd0;
            default:          nb_dx = 2'sd1;
        endcase
    endfunction

    function automatic logic signed [1:0] nb_dy(input logic [2:0] k);
        case (k)
            3'd0, 3'd1, 3'd2: nb_dy = -2'sd1;
            3'd3, 3'd4:       nb_dy = 2'sd0;
            default:          nb_dy = 2'sd1;
        endcase
    endfunction

endpackage

// File: rtl/frm_eg_len.sv
module frm_eg_len #(
    parameter int DW   = 13,
    parameter int LENW = 6
) (
    input  logic signed [DW-1:0] diff_i,
    output logic [LENW-1:0]      len_o
);
    localparam int KW = DW + 2;

    logic signed [KW-1:0] ext;
    logic [KW-1:0]        code;
    logic [KW-1:0]        code_p1;
    logic [LENW-1:0]      msb;

    always_comb begin
        ext = KW'(diff_i);
        if (ext > 0) begin
            code = $unsigned((ext <<< 1) - KW'(1));
        end else begin
            code = $unsigned(-(ext <<< 1));
        end
        code_p1 = code + KW'(1);
        msb = '0;
        for (int i = 0; i < KW; i++) begin
            if (code_p1[i]) begin
                msb = LENW'(i);
            end
        end
        len_o = (msb << 1) + LENW'(1);
    end

endmodule

// File: rtl/frm_mv_rate.sv
module frm_mv_rate #(
    parameter int MVW   = 12,
    parameter int LAMW  = 8,
    parameter int LENW  = 6,
    parameter int PRODW = 15
) (
    input  logic signed [MVW-1:0] cand_x_i,
    input  logic signed [MVW-1:0] cand_y_i,
    input  logic signed [MVW-1:0] pred_x_i,
    input  logic signed [MVW-1:0] pred_y_i,
    input  logic [LAMW-1:0]       lambda_i,
    output logic [PRODW-1:0]      rate_cost_o
);
    localparam int DW    = MVW + 1;
    localparam int RATEW = LENW + 1;

    logic signed [DW-1:0] diff [2];
    logic [LENW-1:0]      len  [2];
    logic [RATEW-1:0]     bits;

    assign diff[0] = DW'(cand_x_i) - DW'(pred_x_i);
    assign diff[1] = DW'(cand_y_i) - DW'(pred_y_i);

    for (genvar ax = 0; ax < 2; ax++) begin : g_axis
        frm_eg_len #(
            .DW  (DW),
            .LENW(LENW)
        ) u_len (
            .diff_i(diff[ax]),
            .len_o (len[ax])
        );
    end

    assign bits        = RATEW'(len[0]) + RATEW'(len[1]);
    assign rate_cost_o = PRODW'(lambda_i) * PRODW'(bits);

endmodule

// File: rtl/frm_satd_acc.sv
module frm_satd_acc #(
    parameter int RW    = 9,
    parameter int NBLK  = 4,
    parameter int SATDW = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              row_vld_i,
    input  logic [4*RW-1:0]   row_i,
    output logic              sum_vld_o,
    output logic [SATDW-1:0]  sum_o
);
    localparam int HW1  = RW + 2;
    localparam int HW2  = RW + 4;
    localparam int ABSW = RW + 7;
    localparam int BCW  = (NBLK > 1) ? $clog2(NBLK) : 1;

    typedef struct packed {
        logic [2:0][3:0][HW1-1:0] hrow;
        logic [1:0]               rcnt;
        logic [BCW-1:0]           bcnt;
        logic [SATDW-1:0]         acc;
        logic                     vld;
        logic [SATDW-1:0]         sum;
    } satd_st_t;

    satd_st_t sq, sd;

    logic signed [HW1-1:0] a  [4];
    logic signed [HW1-1:0] h  [4];
    logic signed [HW1-1:0] s1 [4];
    logic signed [HW2-1:0] vin [4][4];
    logic signed [HW2-1:0] t  [4];
    logic signed [HW2-1:0] v  [4];
    logic signed [HW2-1:0] mag;
    logic [ABSW-1:0]       absum;
    logic [SATDW-1:0]      accn;

    always_comb begin
        sd     = sq;
        sd.vld = 1'b0;

        // horizontal butterfly on the incoming row
        for (int c = 0; c < 4; c++) begin
            a[c] = HW1'($signed(row_i[c*RW +: RW]));
        end
        s1[0] = a[0] + a[1];
        s1[1] = a[0] - a[1];
        s1[2] = a[2] + a[3];
        s1[3] = a[2] - a[3];
        h[0]  = s1[0] + s1[2];
        h[1]  = s1[1] + s1[3];
        h[2]  = s1[0] - s1[2];
        h[3]  = s1[1] - s1[3];

        // vertical butterfly per column, three stored rows plus the current one
        absum = '0;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 3; r++) begin
                vin[c][r] = HW2'($signed(sq.hrow[r][c]));
            end
            vin[c][3] = HW2'(h[c]);
            t[0] = vin[c][0] + vin[c][1];
            t[1] = vin[c][0] - vin[c][1];
            t[2] = vin[c][2] + vin[c][3];
            t[3] = vin[c][2] - vin[c][3];
            v[0] = t[0] + t[2];
            v[1] = t[1] + t[3];
            v[2] = t[0] - t[2];
            v[3] = t[1] - t[3];
            for (int r = 0; r < 4; r++) begin
                mag   = v[r][HW2-1] ? -v[r] : v[r];
                absum = absum + ABSW'($unsigned(mag));
            end
        end
        accn = sq.acc + SATDW'(absum >> 1);

        if (clr_i) begin
            sd.rcnt = '0;
            sd.bcnt = '0;
            sd.acc  = '0;
        end else if (row_vld_i) begin
            if (sq.rcnt != 2'd3) begin
                for (int c = 0; c < 4; c++) begin
                    sd.hrow[sq.rcnt][c] = h[c];
                end
                sd.rcnt = sq.rcnt + 2'd1;
            end else begin
                sd.rcnt = '0;
                if (sq.bcnt == BCW'(NBLK - 1)) begin
                    sd.sum  = accn;
                    sd.vld  = 1'b1;
                    sd.acc  = '0;
                    sd.bcnt = '0;
                end else begin
                    sd.acc  = accn;
                    sd.bcnt = sq.bcnt + BCW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq <= '0;
        end else begin
            sq <= sd;
        end
    end

    assign sum_vld_o = sq.vld;
    assign sum_o     = sq.sum;

endmodule

// File: rtl/frac_mv_refiner.sv
module frac_mv_refiner
    import frm_pkg::*;
#(
    parameter int MVW   = 12,
    parameter int RW    = 9,
    parameter int NBLK  = 4,
    parameter int LAMW  = 8,
    parameter int SATDW = RW + 6 + $clog2(NBLK + 1),
    parameter int LENW  = $clog2(2 * MVW + 6) + 1,
    parameter int PRODW = LAMW + LENW + 1,
    parameter int COSTW = ((SATDW > PRODW) ? SATDW : PRODW) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic signed [MVW-1:0] mv_int_x,
    input  logic signed [MVW-1:0] mv_int_y,
    input  logic signed [MVW-1:0] mv_pred_x,
    input  logic signed [MVW-1:0] mv_pred_y,
    input  logic [LAMW-1:0]       lambda,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic signed [MVW-1:0] req_mv_x,
    output logic signed [MVW-1:0] req_mv_y,
    input  logic                  res_valid,
    input  logic [4*RW-1:0]       res_row,
    output logic                  busy,
    output logic                  done,
    output logic signed [MVW-1:0] best_mv_x,
    output logic signed [MVW-1:0] best_mv_y,
    output logic [COSTW-1:0]      best_cost
);
    localparam int          IDXW      = 5;
    localparam logic [IDXW-1:0] IDX_LAST  = IDXW'(16);
    localparam logic [IDXW-1:0] IDX_PASS1 = IDXW'(8);

    typedef struct packed {
        frm_state_e             st;
        logic [IDXW-1:0]        idx;
        logic signed [MVW-1:0]  ctr_x;
        logic signed [MVW-1:0]  ctr_y;
        logic signed [MVW-1:0]  cur_x;
        logic signed [MVW-1:0]  cur_y;
        logic signed [MVW-1:0]  best_x;
        logic signed [MVW-1:0]  best_y;
        logic [COSTW-1:0]       best_c;
        logic                   done;
    } ctl_st_t;

    ctl_st_t cq, cd;

    logic                  sat_clr;
    logic                  sat_row_vld;
    logic                  sat_vld;
    logic [SATDW-1:0]      sat_sum;
    logic [PRODW-1:0]      rate_cost;
    logic [COSTW-1:0]      cand_cost;
    logic                  better;
    logic signed [MVW-1:0] nb_x, nb_y;
    logic signed [MVW-1:0] nc_x, nc_y;
    logic signed [MVW-1:0] off_x, off_y;
    logic signed [1:0]     kdx, kdy;

    assign sat_row_vld = res_valid && (cq.st == ST_WAIT);

    frm_satd_acc #(
        .RW   (RW),
        .NBLK (NBLK),
        .SATDW(SATDW)
    ) u_satd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (sat_clr),
        .row_vld_i(sat_row_vld),
        .row_i    (res_row),
        .sum_vld_o(sat_vld),
        .sum_o    (sat_sum)
    );

    frm_mv_rate #(
        .MVW  (MVW),
        .LAMW (LAMW),
        .LENW (LENW),
        .PRODW(PRODW)
    ) u_rate (
        .cand_x_i   (cq.cur_x),
        .cand_y_i   (cq.cur_y),
        .pred_x_i   (mv_pred_x),
        .pred_y_i   (mv_pred_y),
        .lambda_i   (lambda),
        .rate_cost_o(rate_cost)
    );

    always_comb begin
        cd      = cq;
        cd.done = 1'b0;
        sat_clr = 1'b0;

        cand_cost = COSTW'(sat_sum) + COSTW'(rate_cost);
        better    = (cq.idx == '0) || (cand_cost < cq.best_c);
        nb_x      = better ? cq.cur_x : cq.best_x;
        nb_y      = better ? cq.cur_y : cq.best_y;

        // centre and step of the next candidate
        nc_x  = (cq.idx == IDX_PASS1) ? nb_x : cq.ctr_x;
        nc_y  = (cq.idx == IDX_PASS1) ? nb_y : cq.ctr_y;
        kdx   = nb_dx(cq.idx[2:0]);
        kdy   = nb_dy(cq.idx[2:0]);
        off_x = {{(MVW-2){kdx[1]}}, kdx};
        off_y = {{(MVW-2){kdy[1]}}, kdy};
        if (cq.idx < IDX_PASS1) begin
            off_x = off_x <<< 1;
            off_y = off_y <<< 1;
        end

        case (cq.st)
            ST_IDLE: begin
                if (start) begin
                    cd.st    = ST_REQ;
                    cd.idx   = '0;
                    cd.ctr_x = mv_int_x;
                    cd.ctr_y = mv_int_y;
                    cd.cur_x = mv_int_x;
                    cd.cur_y = mv_int_y;
                    sat_clr  = 1'b1;
                end
            end
            ST_REQ: begin
                if (req_ready) begin
                    cd.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (sat_vld) begin
                    cd.best_x = nb_x;
                    cd.best_y = nb_y;
                    cd.best_c = better ? cand_cost : cq.best_c;
                    if (cq.idx == IDX_LAST) begin
                        cd.st   = ST_IDLE;
                        cd.done = 1'b1;
                    end else begin
                        cd.idx   = cq.idx + IDXW'(1);
                        cd.ctr_x = nc_x;
                        cd.ctr_y = nc_y;
                        cd.cur_x = nc_x + off_x;
                        cd.cur_y = nc_y + off_y;
                        cd.st    = ST_REQ;
                    end
                end
            end
            default: cd.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq <= '0;
        end else begin
            cq <= cd;
        end
    end

    assign req_valid = (cq.st == ST_REQ);
    assign req_mv_x  = cq.cur_x;
    assign req_mv_y  = cq.cur_y;
    assign busy      = (cq.st != ST_IDLE);
    assign done      = cq.done;
    assign best_mv_x = cq.best_x;
    assign best_mv_y = cq.best_y;
    assign best_cost = cq.best_c;

endmodule

// File: rtl/frm_checks.sv
module frm_checks #(
    parameter int MVW   = 12,
    parameter int COSTW = 19
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic signed [MVW-1:0] req_mv_x,
    input logic signed [MVW-1:0] req_mv_y,
    input logic signed [MVW-1:0] best_mv_x,
    input logic signed [MVW-1:0] best_mv_y,
    input logic [COSTW-1:0]      best_cost
);

    a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && req_valid));

    a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_mv_x) && $stable(req_mv_y)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !req_valid));

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(best_cost) && $stable(best_mv_x) && $stable(best_mv_y)));

    a_r2_no_request_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

endmodule

bind frac_mv_refiner frm_checks #(
    .MVW  (MVW),
    .COSTW(COSTW)
) u_frm_checks (.*);

// File: tb/tb_frac_mv_refiner.sv
module tb_frac_mv_refiner;
    localparam int MVW   = 12;
    localparam int RW    = 9;
    localparam int NBLK  = 4;
    localparam int LAMW  = 8;
    localparam int COSTW = 19;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic signed [MVW-1:0] mv_int_x = '0, mv_int_y = '0;
    logic signed [MVW-1:0] mv_pred_x = '0, mv_pred_y = '0;
    logic [LAMW-1:0]       lambda = '0;
    logic                  req_valid;
    logic                  req_ready = 1'b0;
    logic signed [MVW-1:0] req_mv_x, req_mv_y;
    logic                  res_valid = 1'b0;
    logic [4*RW-1:0]       res_row = '0;
    logic                  busy, done;
    logic signed [MVW-1:0] best_mv_x, best_mv_y;
    logic [COSTW-1:0]      best_cost;

    frac_mv_refiner #(.MVW(MVW), .RW(RW), .NBLK(NBLK), .LAMW(LAMW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mv_int_x(mv_int_x), .mv_int_y(mv_int_y),
        .mv_pred_x(mv_pred_x), .mv_pred_y(mv_pred_y), .lambda(lambda),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_mv_x(req_mv_x), .req_mv_y(req_mv_y),
        .res_valid(res_valid), .res_row(res_row),
        .busy(busy), .done(done),
        .best_mv_x(best_mv_x), .best_mv_y(best_mv_y), .best_cost(best_cost)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int exp_rx[$], exp_ry[$];
    int fin_x[$], fin_y[$], fin_c[$];
    int last_x, last_y, last_c;

    int ndx[8] = '{-1, 0, 1, -1, 1, -1, 0, 1};
    int ndy[8] = '{-1, -1, -1, 0, 0, 1, 1, 1};

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic int eglen(input int v);
        int k, t, n;
        k = (v > 0) ? 2 * v - 1 : -2 * v;
        t = k + 1;
        n = 0;
        while (t > 1) begin
            t = t >> 1;
            n++;
        end
        return 2 * n + 1;
    endfunction

    function automatic int hsign(input int i, input int j);
        return ($countones(i & j) % 2 == 1) ? -1 : 1;
    endfunction

    function automatic int samp(input int cx, input int cy, input int tx, input int ty,
                                input int amp, input int seed, input int sb,
                                input int r, input int c);
        int d, v;
        d = ((cx > tx) ? cx - tx : tx - cx) + ((cy > ty) ? cy - ty : ty - cy);
        v = amp * d * (((r * 5 + c * 3 + sb * 7 + seed) % 7) - 3)
            + amp * (((r * 3 + c + seed) % 5) - 2);
        if (v > 255) v = 255;
        if (v < -255) v = -255;
        return v;
    endfunction

    // monitor: scoreboard for requests and results
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && req_valid && req_ready) begin
                if (exp_rx.size() == 0) begin
                    check(0, "R3", "unexpected request", int'(req_mv_x), 0);
                end else begin
                    int ex, ey;
                    ex = exp_rx.pop_front();
                    ey = exp_ry.pop_front();
                    check(int'(req_mv_x) == ex, "R3", "request x", int'(req_mv_x), ex);
                    check(int'(req_mv_y) == ey, "R3", "request y", int'(req_mv_y), ey);
                end
            end
            if (rst_n && done) begin
                check(!busy, "R8", "busy at done", busy, 0);
                if (fin_x.size() == 0) begin
                    check(0, "R8", "unexpected done", 1, 0);
                end else begin
                    int fx, fy, fc;
                    fx = fin_x.pop_front();
                    fy = fin_y.pop_front();
                    fc = fin_c.pop_front();
                    check(int'(best_mv_x) == fx, "R7", "best x", int'(best_mv_x), fx);
                    check(int'(best_mv_y) == fy, "R7", "best y", int'(best_mv_y), fy);
                    check(int'(best_cost) == fc, "R6", "best cost", int'(best_cost), fc);
                end
            end
        end
    end

    // driver: plays the interpolator and models the expected search
    task automatic run_search(input int ix, input int iy, input int px, input int py,
                              input int lam, input int tx, input int ty, input int amp,
                              input int seed, input bit junk, input bit poke);
        int cx, cy, bx, by, bc, ex, ey, satd, cost;
        int m [4][4];
        @(negedge clk);
        mv_int_x = ix[MVW-1:0];
        mv_int_y = iy[MVW-1:0];
        mv_pred_x = px[MVW-1:0];
        mv_pred_y = py[MVW-1:0];
        lambda = lam[LAMW-1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cx = ix; cy = iy; bx = ix; by = iy; bc = 0;
        for (int n = 0; n < 17; n++) begin
            if (n == 0) begin
                ex = ix; ey = iy;
            end else begin
                int k, stp;
                k = (n - 1) % 8;
                stp = (n <= 8) ? 2 : 1;
                if (n == 9) begin
                    cx = bx; cy = by;
                end
                ex = cx + stp * ndx[k];
                ey = cy + stp * ndy[k];
            end
            exp_rx.push_back(ex);
            exp_ry.push_back(ey);
            while (!req_valid) @(negedge clk);
            if (junk) begin
                // R10: rows before acceptance must not count; R4: request held
                for (int j = 0; j < 2; j++) begin
                    res_valid = 1'b1;
                    res_row = {4{9'h0ff}};
                    @(negedge clk);
                end
                res_valid = 1'b0;
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            satd = 0;
            for (int sb = 0; sb < NBLK; sb++) begin
                int tsum;
                for (int r = 0; r < 4; r++)
                    for (int c = 0; c < 4; c++)
                        m[r][c] = samp(ex, ey, tx, ty, amp, seed, sb, r, c);
                tsum = 0;
                for (int i = 0; i < 4; i++)
                    for (int j = 0; j < 4; j++) begin
                        int acc;
                        acc = 0;
                        for (int a = 0; a < 4; a++)
                            for (int b = 0; b < 4; b++)
                                acc += hsign(i, a) * m[a][b] * hsign(j, b);
                        tsum += (acc < 0) ? -acc : acc;
                    end
                satd += tsum / 2;
                for (int r = 0; r < 4; r++) begin
                    logic [RW-1:0] s0, s1, s2, s3;
                    s0 = m[r][0][RW-1:0]; s1 = m[r][1][RW-1:0];
                    s2 = m[r][2][RW-1:0]; s3 = m[r][3][RW-1:0];
                    res_valid = 1'b1;
                    res_row = {s3, s2, s1, s0};
                    @(negedge clk);
                end
            end
            res_valid = 1'b0;
            if (poke && (n == 5 || n == 12)) begin
                start = 1'b1;   // R9: ignored while busy
                mv_int_x = '0;
                mv_int_y = '0;
                @(negedge clk);
                start = 1'b0;
            end
            cost = satd + lam * (eglen(ex - px) + eglen(ey - py));
            if (n == 0 || cost < bc) begin
                bx = ex; by = ey; bc = cost;
            end
        end
        fin_x.push_back(bx);
        fin_y.push_back(by);
        fin_c.push_back(bc);
        last_x = bx; last_y = by; last_c = bc;
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check(int'(best_mv_x) == bx && int'(best_cost) == bc, "R8", "result held",
              int'(best_cost), bc);
        check(fin_x.size() == 0, "R8", "done seen", fin_x.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        check(!busy, "R1", "busy after reset", busy, 0);
        check(!req_valid, "R1", "req_valid after reset", req_valid, 0);
        check(!done, "R1", "done after reset", done, 0);
        check(best_cost == '0, "R1", "best_cost after reset", int'(best_cost), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 R5: minimum at the integer centre
        run_search(20, -8, 20, -8, 4, 20, -8, 6, 1, 0, 0);
        // R3: minimum at a half-plus-quarter offset, second pass recentred
        run_search(40, 12, 0, 0, 1, 43, 9, 5, 3, 0, 0);
        // R7 R10: zero residue, rate only, ties, junk rows before acceptance
        run_search(8, 8, 5, 10, 3, 0, 0, 0, 0, 1, 0);
        // R5 R9: clipped samples, negative vectors, stray starts
        run_search(-100, -60, -90, -64, 0, -101, -59, 200, 5, 0, 1);
        // R6: rate term dominates
        run_search(-4, 16, 4, 0, 255, -6, 18, 1, 2, 0, 0);
        repeat (10) @(negedge clk);
        check(exp_rx.size() == 0, "R3", "requests outstanding", exp_rx.size(), 0);
        finish_run();
    end

endmodule